// File: doc/BRIEF.md
# Vector Reciprocal Estimate Unit

This datapath takes a 128-bit vector holding four IEEE-754 single-precision lanes and returns, for every lane, an approximation of its reciprocal. The lanes do not interact. A one-bit handshake goes with each vector, and the answer appears a fixed two cycles later. A new vector can be accepted on every clock.

Each lane handles the special operand classes itself: signed zeros, infinities, NaNs and denormals. A per-vector flush control chooses how denormals are treated. When the flush bit is set, denormal operands count as zero, and results that would be denormal are forced to zero. When the flush bit is clear, denormal operands are normalised before the estimate, and tiny results are delivered as denormals. The unit never signals a status condition or an exception.

For a finite non-zero lane, a small seed table is indexed by the leading fraction bits. One hardware refinement step on that seed then gives a quotient good to well beyond 12 bits. The result exponent is formed separately from the operand exponent.

Top module: `recip_est_vec`

## Requirements
- R1: Lane k (k = 0..3) occupies bits 127-32k down to 96-32k of both `in_vec` and `out_vec`, and each result lane depends only on the same input lane.
- R2: For a normal operand with a normal result, the result has the operand's sign and differs from the true reciprocal by at most 1/4096 of its magnitude.
- R3: An operand of +0 (0x00000000) gives +infinity (0x7F800000), and -0 gives -infinity (0xFF800000).
- R4: An operand of +infinity gives +0, and -infinity gives -0.
- R5: For a NaN operand (exponent field 0xFF, fraction non-zero), the result is the operand with fraction bit 22 forced to 1. A quiet NaN therefore comes out unchanged.
- R6: With `flush_dn` = 1, a denormal operand (exponent field 0, fraction non-zero) gives infinity of the operand's sign.
- R7: With `flush_dn` = 1, a result below the smallest normal magnitude is returned as zero of the operand's sign.
- R8: With `flush_dn` = 0, a denormal operand is normalised and estimated as in R2. A reciprocal too large to represent becomes infinity of the operand's sign.
- R9: With `flush_dn` = 0, a result below the smallest normal magnitude is returned as a denormal of the operand's sign. It is within 1/4096 relative plus 2^-148 absolute of the true value.
- R10: `out_valid` is high exactly two cycles after `in_valid` was sampled high, and low two cycles after it was sampled low. One vector per cycle is sustained.
- R11: An operand whose fraction field is zero (an exact power of two) gives the exact power-of-two reciprocal. For 2^127 with `flush_dn` = 0, that reciprocal is the denormal 0x00400000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand vector present this cycle |
| in_vec | input | 128 | Four binary32 operands, lane 0 in the top word |
| flush_dn | input | 1 | Denormal flush control for this vector |
| out_valid | output | 1 | Result vector present this cycle |
| out_vec | output | 128 | Four binary32 reciprocal estimates, lane 0 in the top word |

## Verification
The lane checks relate an operand to the result two edges later, whether or not the lane is valid. They therefore assume that `in_vec` and `flush_dn` carry defined values on every cycle after reset. The bench drives them from the first cycle and keeps the last values during idle cycles. The handshake checks assume that `in_valid` stays low while reset is held, and the bench asserts reset only with the valid line low. Results at the overflow and underflow thresholds may round either way. The reference model therefore accepts either outcome only within a band of 2^-10 around those thresholds, and the stimulus places directed operands clearly on one side of them.

// File: rtl/recip_pkg.sv
package recip_pkg;

  localparam int FP_W   = 32;
  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;

  typedef enum logic [1:0] {
    CL_NUM,
    CL_ZERO,
    CL_INF,
    CL_NAN
  } opclass_t;

  // leading zeros of a 23-bit fraction (23 when all zero)
  function automatic logic [4:0] lead_zeros(input logic [FRAC_W-1:0] v);
    logic [4:0] cnt;
    logic       hit;
    cnt = '0;
    hit = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      cnt = cnt + 5'd1;
      end
    end
    return cnt;
  endfunction

  // rounded 1/(1 + (i+0.5)/2^idx_w), scaled by 2^(seed_w-1)
  function automatic logic [31:0] seed_entry(input int idx, input int idx_w, input int seed_w);
    longint num;
    longint den;
    num = longint'(1) << (seed_w + idx_w);
    den = (longint'(1) << (idx_w + 1)) + 2 * longint'(idx) + 1;
    return 32'((2 * num + den) / (2 * den));
  endfunction

endpackage

// File: rtl/recip_seed_rom.sv
module recip_seed_rom
  import recip_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int SEED_W = 13
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  addr,
  output logic [SEED_W-1:0] q
);

  // synchronous read of a computed constant table
  always_ff @(posedge clk) begin
    q <= SEED_W'(seed_entry(int'(addr), IDX_W, SEED_W));
  end

endmodule

// File: rtl/recip_lane.sv
module recip_lane
  import recip_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int SEED_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FP_W-1:0] op,
  input  logic            ftz,
  output logic [FP_W-1:0] res
);

  localparam int YF  = SEED_W - 1;
  localparam int PW  = FRAC_W + 1 + SEED_W;
  localparam int TW  = 26;
  localparam int MW  = SEED_W + TW;
  localparam int Y1W = YF + 24;
  localparam logic [TW-1:0] TWO = {1'b1, {(TW-1){1'b0}}};

  // ---------------- stage 0: classify and normalise ----------------
  logic [EXP_W-1:0]   e0;
  logic [FRAC_W-1:0]  f0;
  logic [4:0]         lz0;
  opclass_t           cls0;
  logic [FRAC_W-1:0]  nfrac0;
  logic signed [10:0] eeff0;

  always_comb begin
    e0     = op[30:23];
    f0     = op[22:0];
    lz0    = lead_zeros(f0);
    cls0   = CL_NUM;
    nfrac0 = f0;
    eeff0  = $signed({3'b000, e0});
    if (e0 == 8'hFF) begin
      cls0 = (f0 != '0) ? CL_NAN : CL_INF;
    end else if (e0 == 8'h00) begin
      if (f0 == '0 || ftz) begin
        cls0 = CL_ZERO;
      end else begin
        nfrac0 = f0 << (lz0 + 5'd1);
        eeff0  = 11'sd0 - $signed({6'd0, lz0});
      end
    end
  end

  // ---------------- stage 1 registers ----------------
  logic [FP_W-1:0]    s1_op;
  opclass_t           s1_cls;
  logic [FRAC_W-1:0]  s1_frac;
  logic signed [10:0] s1_eeff;
  logic               s1_ftz;
  logic [SEED_W-1:0]  seed;

  recip_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_rom (
    .clk  (clk),
    .addr (nfrac0[FRAC_W-1 -: IDX_W]),
    .q    (seed)
  );

  always_ff @(posedge clk) begin
    s1_op   <= op;
    s1_cls  <= cls0;
    s1_frac <= nfrac0;
    s1_eeff <= eeff0;
    s1_ftz  <= ftz;
  end

  // ---------------- stage 1: refine and pack ----------------
  logic [23:0]        mant;
  logic [PW-1:0]      prod;
  logic [TW-1:0]      p24;
  logic [TW-1:0]      tcorr;
  logic [Y1W-1:0]     y1;
  logic [23:0]        sig;
  logic signed [10:0] exp_r;
  logic signed [10:0] shamt;
  logic [FP_W-1:0]    nxt;
  logic               sgn;

  always_comb begin
    sgn   = s1_op[31];
    mant  = {1'b1, s1_frac};
    prod  = PW'(mant) * PW'(seed);
    p24   = TW'(prod >> (YF - 1));
    tcorr = TWO - p24;
    y1    = Y1W'(MW'(seed) * MW'(tcorr));
    if (s1_frac == '0) begin
      sig   = 24'h800000;
      exp_r = 11'sd254 - s1_eeff;
    end else if (y1[Y1W-1]) begin
      sig   = 24'(y1 >> (Y1W - 24));
      exp_r = 11'sd253 - s1_eeff;
    end else begin
      sig   = 24'(y1 >> (Y1W - 25));
      exp_r = 11'sd252 - s1_eeff;
    end
    shamt = 11'sd1 - exp_r;
    case (s1_cls)
      CL_NAN:  nxt = s1_op | 32'h0040_0000;
      CL_INF:  nxt = {sgn, 31'h0};
      CL_ZERO: nxt = {sgn, 8'hFF, 23'h0};
      default: begin
        if (exp_r >= 11'sd255)    nxt = {sgn, 8'hFF, 23'h0};
        else if (exp_r >= 11'sd1) nxt = {sgn, exp_r[7:0], sig[22:0]};
        else if (s1_ftz)          nxt = {sgn, 31'h0};
        else                      nxt = {sgn, 8'h00, 23'(sig >> shamt)};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    res <= nxt;
  end

  // ---------------- assertions ----------------
  a_r3_zero_to_inf: assert property (@(posedge clk) disable iff (rst)
    (op[30:0] == 31'h0) |-> ##2 (res == {$past(op[31], 2), 31'h7F80_0000}));

  a_r4_inf_to_zero: assert property (@(posedge clk) disable iff (rst)
    (op[30:0] == 31'h7F80_0000) |-> ##2 (res == {$past(op[31], 2), 31'h0}));

  a_r5_nan_quieted: assert property (@(posedge clk) disable iff (rst)
    (op[30:23] == 8'hFF && op[22:0] != 23'h0) |-> ##2 (res == ($past(op, 2) | 32'h0040_0000)));

  a_r6_flush_input: assert property (@(posedge clk) disable iff (rst)
    (ftz && op[30:23] == 8'h00) |-> ##2 (res == {$past(op[31], 2), 31'h7F80_0000}));

  a_r7_no_denorm_out: assert property (@(posedge clk) disable iff (rst)
    ftz |-> ##2 !(res[30:23] == 8'h00 && res[22:0] != 23'h0));

  a_r2_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (op[30:23] != 8'hFF || op[22:0] == 23'h0) |-> ##2 (res[31] == $past(op[31], 2)));

endmodule

// File: rtl/recip_est_vec.sv
module recip_est_vec
  import recip_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int IDX_W  = 6,
  parameter int SEED_W = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [LANES*32-1:0]   in_vec,
  input  logic                  flush_dn,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   out_vec
);

  localparam int VW = LANES * FP_W;

  logic v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  // lane 0 sits in the most significant word (R1)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LO = VW - FP_W * (k + 1);
    recip_lane #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .op  (in_vec[LO +: FP_W]),
      .ftz (flush_dn),
      .res (out_vec[LO +: FP_W])
    );
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

endmodule

// File: tb/sim_recip_est_vec.sv
module sim_recip_est_vec;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_vec = '0;
  logic         flush_dn = 1'b0;
  logic         out_valid;
  logic [127:0] out_vec;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  done = 0;
  logic h0 = 1'b0, h1 = 1'b0;
  logic [128:0] pend[$];

  localparam logic [127:0] R1_IN  = {32'h40000000, 32'hFF800000, 32'h7FC00000, 32'h00000000};
  localparam logic [127:0] R1_OUT = {32'h3F000000, 32'h80000000, 32'h7FC00000, 32'h7F800000};

  real BIG, MINN, TINY;

  recip_est_vec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .flush_dn(flush_dn), .out_valid(out_valid), .out_vec(out_vec)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic real mag(input logic [31:0] b);
    int  ex;
    real fr;
    ex = int'(b[30:23]);
    fr = real'(b[22:0]);
    if (ex == 0) return fr * (2.0 ** (-149));
    return (1.0 + fr / 8388608.0) * (2.0 ** (ex - 127));
  endfunction

  task automatic note(input bit ok, input string req, input string detail);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic check_lane(input int ln, input logic fz, input logic [31:0] a, input logic [31:0] g);
    logic [7:0]  e;
    logic [22:0] f;
    logic        s;
    logic [31:0] x;
    int          k;
    real         r, gv, err;
    bit          ok, ok_inf, ok_zero;
    string       req;
    e = a[30:23]; f = a[22:0]; s = a[31];
    if (e == 8'hFF && f != 0) begin
      x = a | 32'h00400000;
      note(g == x, "R5", $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
    end else if (e == 8'hFF) begin
      x = {s, 31'h0};
      note(g == x, "R4", $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
    end else if (e == 0 && (f == 0 || fz)) begin
      x = {s, 31'h7F800000};
      note(g == x, (f == 0) ? "R3" : "R6", $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
    end else if (e != 0 && f == 0) begin
      k = 254 - int'(e);
      if (k >= 1)   begin x = {s, 8'(k), 23'h0};    req = "R11"; end
      else if (fz)  begin x = {s, 31'h0};           req = "R7";  end
      else          begin x = {s, 8'h0, 23'h400000}; req = "R11"; end
      note(g == x, req, $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
    end else begin
      r  = 1.0 / mag(a);
      gv = mag(g);
      req = (e == 0) ? "R8" : "R2";
      if (r >= BIG) begin
        x = {s, 31'h7F800000};
        note(g == x, "R8", $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
      end else if (fz && r < MINN) begin
        x = {s, 31'h0};
        note(g == x, "R7", $sformatf("lane%0d in=%h actual=%h expected=%h", ln, a, g, x));
      end else begin
        ok_inf  = (r > BIG * (1.0 - 2.0 ** (-10))) && (g == {s, 31'h7F800000});
        ok_zero = fz && (r < MINN * (1.0 + 2.0 ** (-10))) && (g == {s, 31'h0});
        err = (gv > r) ? gv - r : r - gv;
        ok  = (g[31] == s) && (g[30:23] != 8'hFF) && (err <= r / 4096.0 + TINY);
        if (r < MINN) req = fz ? "R7" : "R9";
        note(ok || ok_inf || ok_zero, req,
             $sformatf("lane%0d in=%h actual=%h (%g) expected=~%g", ln, a, g, gv, r));
      end
    end
  endtask

  task automatic step(input logic v, input logic [127:0] vec, input logic fz);
    logic [128:0] ent;
    @(negedge clk);
    note(out_valid == h1, "R10", $sformatf("valid actual=%0b expected=%0b", out_valid, h1));
    if (out_valid) begin
      if (pend.size() == 0) begin
        note(1'b0, "R10", "actual=extra result expected=none");
      end else begin
        ent = pend.pop_front();
        for (int ln = 0; ln < 4; ln++)  // R1: lane ln at bits 127-32ln
          check_lane(ln, ent[128], ent[127 - 32*ln -: 32], out_vec[127 - 32*ln -: 32]);
        if (ent[127:0] == R1_IN)
          note(out_vec == R1_OUT, "R1", $sformatf("actual=%h expected=%h", out_vec, R1_OUT));
      end
    end
    h1 = h0;
    h0 = v;
    in_valid = v;
    if (v) begin
      in_vec   = vec;
      flush_dn = fz;
      pend.push_back({fz, vec});
    end
  endtask

  function automatic logic [31:0] rnd_lane();
    logic [31:0] w;
    int          sel;
    w   = $urandom;
    sel = $urandom % 8;
    case (sel)
      0: ;
      1: w[30:23] = 8'h00;
      2: w[30:23] = 8'(250 + $urandom % 5);
      3: begin w[30:23] = 8'(1 + $urandom % 254); w[22:0] = '0; end
      default: w[30:23] = 8'(1 + $urandom % 254);
    endcase
    return w;
  endfunction

  initial begin
    BIG  = 2.0 ** 128;
    MINN = 2.0 ** (-126);
    TINY = 2.0 ** (-148);
    repeat (4) @(negedge clk);
    note(out_valid == 1'b0, "R10", $sformatf("reset valid actual=%0b expected=0", out_valid));
    rst = 1'b0;

    step(1, R1_IN, 0);
    step(1, {32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000}, 0);  // R3 R4
    step(1, {32'h7FC01234, 32'h7F800001, 32'hFF812345, 32'h3F800000}, 0);  // R5
    step(1, {32'h40000000, 32'h3E800000, 32'hC1000000, 32'h7F000000}, 0);  // R11
    step(1, {32'h40000000, 32'h3E800000, 32'hC1000000, 32'h7F000000}, 1);  // R7
    step(1, {32'h00000001, 32'h80400000, 32'h007FFFFF, 32'h00000000}, 1);  // R6
    step(0, '0, 0);
    step(1, {32'h00400000, 32'h00000001, 32'h80200000, 32'h007FFFFF}, 0);  // R8
    step(1, {32'h7F7FFFFF, 32'h7F000001, 32'hFE800000, 32'h7E900000}, 0);  // R9
    step(1, {32'h7F7FFFFF, 32'h7F000001, 32'hFE800000, 32'h7E900000}, 1);  // R7
    step(1, {32'h40400000, 32'hBDCCCCCD, 32'h3FFFFFFF, 32'h3F800001}, 0);  // R2
    step(0, '0, 0);
    step(0, '0, 0);

    for (int i = 0; i < 40; i++)   // back-to-back R10
      step(1, {rnd_lane(), rnd_lane(), rnd_lane(), rnd_lane()}, 1'($urandom % 2));
    for (int i = 0; i < 500; i++)
      step(($urandom % 4) != 0, {rnd_lane(), rnd_lane(), rnd_lane(), rnd_lane()}, 1'($urandom % 2));
    for (int i = 0; i < 4; i++) step(0, '0, 0);

    note(pend.size() == 0, "R10", $sformatf("outstanding actual=%0d expected=0", pend.size()));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule